// File: doc/BRIEF.md
# Serial PCM Byte Port with Automatic Sync-Width Detection

This block moves one 8-bit sample in each direction per frame over a serial PCM link. The link is timed from outside: a bit clock and a frame sync arrive as plain inputs. They are resampled into a faster system clock, which must run at least four times the bit-clock rate. Working in the system clock lets the port find bit-clock edges and time half a bit period.

Each frame begins on the first bit-clock falling edge that sees the sync high. The port does not need to be told which framing is in use. It measures how many bit-clock falls the sync pulse covered. A pulse of one fall means short framing. A wider pulse means long framing. The measured width is applied to the frame after the pulse. In both framings the transmit line is enabled from the first rising edge of the word and released halfway through the last bit. In long framing, a drop of the sync during the word releases the line at once.

Received bits are sampled on falling edges. The finished byte is presented with a one-cycle strobe. A power-down input silences the port. After power-down ends, the transmit line stays released for two further frames, so that the port cannot collide with another driver while the link settles.

Top module: `pcm_serial_port`

## Requirements
- R1: A frame starts on a bit-clock fall where the sync is high, provided the sync was low at the previous fall. A sync pulse that spans one fall selects short framing, and a pulse that spans two or more falls selects long framing. Each frame uses the framing measured from the pulse before it. After reset the framing is short.
- R2: The tx byte is sent MSB first. The k-th bit-clock rise after the frame-start fall drives bit 8-k on sdout and raises sdout_oe. sdout_oe is low out of reset.
- R3: In short framing, sdout_oe falls halfway through the LSB. Half a bit period is half the measured rise-to-rise interval of the bit clock.
- R4: In long framing, a fall of the sync while a word is in progress drops sdout_oe at once, and no later bit of that word is driven. If the sync fall and a bit-clock rise coincide, the release takes precedence.
- R5: Incoming data is sampled on the 8 bit-clock falls that follow the frame-start fall, MSB first. rx_byte then updates, and rx_valid pulses for exactly one cycle.
- R6: While pwrdn is high, sdout_oe is low, no frame starts and rx_valid stays low.
- R7: After pwrdn falls, the first two frames do not raise sdout_oe. The third frame drives normally.
- R8: The tx byte is captured at the frame-start fall. Later changes to tx_byte do not alter the word in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn | input | 1 | Power-down; silences the port while high |
| bclk | input | 1 | External bit clock |
| fsync | input | 1 | External frame sync |
| sdin | input | 1 | Serial receive data |
| tx_byte | input | 8 | Byte to transmit in the next frame |
| sdout | output | 1 | Serial transmit data |
| sdout_oe | output | 1 | Enable for the transmit tri-state driver |
| rx_byte | output | 8 | Last byte received |
| rx_valid | output | 1 | One-cycle strobe when rx_byte updates |

## Verification
In long framing, a drop of the sync during the word can reach the transmit path in the same system cycle as the bit-clock rise that shifts out the next bit. The bench provokes this by lowering the sync and raising the bit clock in the same cycle, at each bit position from the MSB to the LSB. It expects the release to win: the bits before the drop appear, and none after it does. The bench also runs wide pulses in frames that are still in short framing and single-fall pulses in frames that are in long framing. This confirms that the framing follows the previous pulse and not the current one.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
   typedef enum logic {
      FRM_SHORT = 1'b0,
      FRM_LONG  = 1'b1
   } frm_mode_e;
endpackage

// File: rtl/pcm_sync_chain.sv
module pcm_sync_chain #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int CHAIN_W = WIDTH * STAGES;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pcm_sync_chain: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("pcm_sync_chain: WIDTH must be at least 1");
      end
   endgenerate

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
   end

   assign q = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/pcm_frame_ctrl.sv
module pcm_frame_ctrl
   import pcm_port_pkg::*;
#(
   parameter int WCNT_W       = 4,
   parameter int GUARD_FRAMES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwrdn,
   input  logic bclk_fall,
   input  logic fs_lvl,
   output logic tx_start,
   output logic rx_start,
   output logic long_act
);
   localparam int GUARD_W = (GUARD_FRAMES < 1) ? 1 : $clog2(GUARD_FRAMES + 1);

   generate
      if (WCNT_W < 2) begin : g_bad_wcnt
         $error("pcm_frame_ctrl: WCNT_W must be at least 2");
      end
   endgenerate

   logic              fs_at_fall_q;
   logic [WCNT_W-1:0] wcnt_q;
   frm_mode_e         mode_next_q, mode_act_q;
   logic [GUARD_W-1:0] guard_q;
   logic              start_raw;

   assign start_raw = bclk_fall && fs_lvl && !fs_at_fall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_at_fall_q <= 1'b0;
         wcnt_q       <= '0;
         mode_next_q  <= FRM_SHORT;
      end else if (bclk_fall) begin
         fs_at_fall_q <= fs_lvl;
         if (fs_lvl) begin
            if (!fs_at_fall_q)  wcnt_q <= WCNT_W'(1);
            else if (!(&wcnt_q)) wcnt_q <= wcnt_q + 1'b1;
         end else if (fs_at_fall_q) begin
            mode_next_q <= (wcnt_q > WCNT_W'(1)) ? FRM_LONG : FRM_SHORT;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_act_q <= FRM_SHORT;
         guard_q    <= '0;
      end else if (pwrdn) begin
         guard_q <= GUARD_W'(GUARD_FRAMES);
      end else if (start_raw) begin
         mode_act_q <= mode_next_q;
         if (guard_q != '0) guard_q <= guard_q - 1'b1;
      end
   end

   assign rx_start = start_raw && !pwrdn;
   assign tx_start = rx_start && (guard_q == '0);
   assign long_act = (mode_act_q == FRM_LONG);

   // R6: no frame begins while powered down
   p_no_start_pwrdn_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pwrdn |-> !rx_start);
   // R7: the first frame after power-down never starts transmission
   p_guard_first_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwrdn) |-> !tx_start);
endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path #(
   parameter int WORD_W = 8,
   parameter int PER_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwrdn,
   input  logic              bclk_rise,
   input  logic              fs_fall,
   input  logic              tx_start,
   input  logic              long_act,
   input  logic [WORD_W-1:0] tx_byte,
   output logic              sdout,
   output logic              sdout_oe
);
   localparam int IDX_W = $clog2(WORD_W + 1);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("pcm_tx_path: WORD_W must be at least 2");
      end
      if (PER_W < 3) begin : g_bad_per
         $error("pcm_tx_path: PER_W must be at least 3");
      end
   endgenerate

   logic [PER_W-1:0]  since_q, per_q, half_q, half_init;
   logic [WORD_W-1:0] sh_q;
   logic [IDX_W-1:0]  idx_q;
   logic              go_q, run_q, sd_q, oe_q, cut;

   // bit period measured between bit-clock rises
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
         per_q   <= '0;
      end else if (bclk_rise) begin
         per_q   <= (&since_q) ? since_q : since_q + 1'b1;
         since_q <= '0;
      end else if (!(&since_q)) begin
         since_q <= since_q + 1'b1;
      end
   end

   assign half_init = ((per_q >> 1) == '0) ? PER_W'(1) : (per_q >> 1);
   assign cut       = long_act && fs_fall && (go_q || run_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         idx_q  <= '0;
         go_q   <= 1'b0;
         run_q  <= 1'b0;
         half_q <= '0;
         sd_q   <= 1'b0;
         oe_q   <= 1'b0;
      end else if (pwrdn || cut) begin
         go_q  <= 1'b0;
         run_q <= 1'b0;
         oe_q  <= 1'b0;
      end else if (tx_start) begin
         sh_q  <= tx_byte;
         idx_q <= '0;
         go_q  <= 1'b1;
         run_q <= 1'b0;
         oe_q  <= 1'b0;
      end else if (bclk_rise && go_q) begin
         sd_q  <= sh_q[WORD_W-1];
         sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
         oe_q  <= 1'b1;
         idx_q <= idx_q + 1'b1;
         if (idx_q == IDX_W'(WORD_W - 1)) begin
            go_q   <= 1'b0;
            run_q  <= 1'b1;
            half_q <= half_init;
         end
      end else if (run_q) begin
         if (half_q <= PER_W'(1)) begin
            oe_q  <= 1'b0;
            run_q <= 1'b0;
         end else begin
            half_q <= half_q - 1'b1;
         end
      end
   end

   assign sdout    = sd_q;
   assign sdout_oe = oe_q;

   // R2: the driver only turns on at a bit-clock rise
   p_oe_on_at_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdout_oe) |-> $past(bclk_rise));
   // R4: a sync drop in long framing releases the line on the next cycle
   p_long_cut_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (long_act && fs_fall && (go_q || run_q)) |=> !sdout_oe);
   // R6: power-down forces the driver off
   p_pwrdn_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pwrdn |=> !sdout_oe);
endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwrdn,
   input  logic              bclk_fall,
   input  logic              rx_start,
   input  logic              sd_lvl,
   output logic [WORD_W-1:0] rx_byte,
   output logic              rx_valid
);
   localparam int IDX_W = $clog2(WORD_W + 1);

   logic [WORD_W-1:0] sh_q, byte_q;
   logic [IDX_W-1:0]  idx_q;
   logic              on_q, vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         byte_q <= '0;
         idx_q  <= '0;
         on_q   <= 1'b0;
         vld_q  <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (pwrdn) begin
            on_q <= 1'b0;
         end else if (rx_start) begin
            on_q  <= 1'b1;
            idx_q <= '0;
         end else if (bclk_fall && on_q) begin
            sh_q  <= {sh_q[WORD_W-2:0], sd_lvl};
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_W'(WORD_W - 1)) begin
               byte_q <= {sh_q[WORD_W-2:0], sd_lvl};
               vld_q  <= 1'b1;
               on_q   <= 1'b0;
            end
         end
      end
   end

   assign rx_byte  = byte_q;
   assign rx_valid = vld_q;

   // R5: the strobe lasts a single cycle
   p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   // R5: the strobe follows a sampling fall
   p_valid_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(bclk_fall));
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
   parameter int WORD_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int PER_W        = 8,
   parameter int WCNT_W       = 4,
   parameter int GUARD_FRAMES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwrdn,
   input  logic              bclk,
   input  logic              fsync,
   input  logic              sdin,
   input  logic [WORD_W-1:0] tx_byte,
   output logic              sdout,
   output logic              sdout_oe,
   output logic [WORD_W-1:0] rx_byte,
   output logic              rx_valid
);
   logic [2:0] syn;
   logic [1:0] prv_q;
   logic       bclk_rise, bclk_fall, fs_fall;
   logic       tx_start, rx_start, long_act;

   pcm_sync_chain #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sdin, fsync, bclk}), .q(syn));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv_q <= '0;
      else        prv_q <= syn[1:0];
   end

   assign bclk_rise = syn[0] && !prv_q[0];
   assign bclk_fall = !syn[0] && prv_q[0];
   assign fs_fall   = !syn[1] && prv_q[1];

   pcm_frame_ctrl #(.WCNT_W(WCNT_W), .GUARD_FRAMES(GUARD_FRAMES)) u_frame (
      .clk(clk), .rst_n(rst_n), .pwrdn(pwrdn), .bclk_fall(bclk_fall),
      .fs_lvl(syn[1]), .tx_start(tx_start), .rx_start(rx_start),
      .long_act(long_act));

   pcm_tx_path #(.WORD_W(WORD_W), .PER_W(PER_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .pwrdn(pwrdn), .bclk_rise(bclk_rise),
      .fs_fall(fs_fall), .tx_start(tx_start), .long_act(long_act),
      .tx_byte(tx_byte), .sdout(sdout), .sdout_oe(sdout_oe));

   pcm_rx_path #(.WORD_W(WORD_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .pwrdn(pwrdn), .bclk_fall(bclk_fall),
      .rx_start(rx_start), .sd_lvl(syn[2]), .rx_byte(rx_byte),
      .rx_valid(rx_valid));

   // R1: the framing choice only changes when a frame starts
   p_mode_moves_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(long_act) |-> $past(rx_start));
   // R6: the driver never turns on during power-down
   p_no_drive_pwrdn_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdout_oe) |-> !pwrdn);
endmodule

// File: tb/pcm_serial_port_bench.sv
module pcm_serial_port_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwrdn = 1'b0;
   logic       bclk = 1'b0;
   logic       fsync = 1'b0;
   logic       sdin = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic       sdout, sdout_oe, rx_valid;
   logic [7:0] rx_byte;

   int         nvec = 0;
   int         nfail = 0;
   int         nrx = 0;
   int         prev_w = 1;
   logic [7:0] rx_got = 8'h00;

   always #4 clk = ~clk;

   pcm_serial_port u_pcm_serial_port (
      .clk(clk), .rst_n(rst_n), .pwrdn(pwrdn), .bclk(bclk), .fsync(fsync),
      .sdin(sdin), .tx_byte(tx_byte), .sdout(sdout), .sdout_oe(sdout_oe),
      .rx_byte(rx_byte), .rx_valid(rx_valid));

   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         nrx    = nrx + 1;
         rx_got = rx_byte;
      end
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      nvec = nvec + 1;
      if (!ok) begin
         nfail = nfail + 1;
         $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         bclk = 1'b1;
         repeat (8) @(negedge clk);
         bclk = 1'b0;
         repeat (8) @(negedge clk);
      end
   endtask

   // one frame: period 0 carries the start fall, periods 1..8 the bits
   task automatic frame(input int w, input logic [7:0] txb, input logic [7:0] rxb,
                        input bit en, input string tag);
      bit lng;
      int rx0;
      int exp_n;
      lng = (prev_w > 1);
      rx0 = nrx;
      tx_byte = txb;
      for (int p = 0; p < 10; p++) begin
         bit    drv;
         string rq;
         bclk = 1'b1;
         if (p == 0) fsync = 1'b1;
         if (p >= 1 && p == w) fsync = 1'b0;
         if (p >= 1 && p <= 8) sdin = rxb[8-p];
         if (p == 2) tx_byte = ~txb;
         repeat (6) @(negedge clk);
         if (p >= 1 && p <= 8) begin
            drv = en && (!lng || p < w);
            if (!en) rq = tag;
            else if (lng && p >= w) rq = "R4";
            else if (p >= 3) rq = "R8";
            else rq = tag;
            chk(sdout_oe === drv, rq, int'(sdout_oe), int'(drv));
            if (drv) chk(sdout === txb[8-p], rq, int'(sdout), int'(txb[8-p]));
         end
         repeat (2) @(negedge clk);
         bclk = 1'b0;
         repeat (6) @(negedge clk);
         if (p == 8) chk(sdout_oe === 1'b0, lng ? "R4" : "R3", int'(sdout_oe), 0);
         repeat (2) @(negedge clk);
      end
      exp_n = pwrdn ? 0 : 1;
      chk((nrx - rx0) == exp_n, pwrdn ? "R6" : "R5", nrx - rx0, exp_n);
      if (!pwrdn) chk(rx_got === rxb, "R5", int'(rx_got), int'(rxb));
      prev_w = w;
   endtask

   initial begin
      #(100000 * 8);
      nfail = nfail + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(sdout_oe === 1'b0, "R2", int'(sdout_oe), 0);
      chk(rx_valid === 1'b0, "R5", int'(rx_valid), 0);
      rst_n = 1'b1;
      idle(3);

      // R2 R5 R8: short framing over a spread of byte values
      for (int i = 0; i < 12; i++)
         frame(1, 8'(i * 29 + 3), 8'(i * 53 + 7), 1'b1, "R2");

      // R1: a wide pulse still runs short, later frames follow each width
      frame(9, 8'hA5, 8'h3C, 1'b1, "R1");
      for (int w = 2; w <= 9; w++)
         frame(w, 8'(w * 17 + 1), 8'(w * 41 + 9), 1'b1, "R1");
      frame(1, 8'hF0, 8'h0F, 1'b1, "R4");
      frame(1, 8'h81, 8'h7E, 1'b1, "R1");

      // R6 R7: power-down and the two silent frames after it
      pwrdn = 1'b1;
      idle(1);
      frame(1, 8'hC3, 8'h5A, 1'b0, "R6");
      pwrdn = 1'b0;
      idle(1);
      frame(1, 8'h3C, 8'h96, 1'b0, "R7");
      frame(1, 8'h69, 8'hE1, 1'b0, "R7");
      frame(1, 8'hB4, 8'h2D, 1'b1, "R7");

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule